// File: doc/BRIEF.md
# Two-Window Button Hold Timer

This controller watches two push-button levels and drives a one-bit selector. A fresh press of the first button on its own, with the second button released, opens a short arming window. The selector stays low while that window runs. If either button is newly pressed before the arming window runs out, the selector goes high and a longer hold window starts. Any new press during the hold window starts that window again from zero. When the hold window runs out with both buttons released, the selector drops and the block goes back to idle.

The button inputs must already be synchronized to the clock and debounced. One count step is one clock cycle, so any slower time base has to come from outside the block. The current count and state are brought out so they can be watched while debugging.

Top module: `btn_window_timer`

## Requirements
- R1: In idle (state code 0), when no qualifying press arrives, `sel` is 0 and `dbg_count` stays at 0.
- R2: In idle, a rising edge on `btn_a` while `btn_b` is low moves the block to arm (state code 1) at the next edge with count 0 and `sel` 0. The count then rises by one on each edge.
- R3: In arm, if no press arrives, the window lasts ARM_LEN cycles (counts 0 to ARM_LEN-1). The next edge returns the block to idle with count 0 and `sel` 0.
- R4: A rising edge on either button during arm moves the block to hold (state code 2) at the next edge, with count 0 and `sel` 1.
- R5: `sel` is 1 in every cycle of hold. The hold count rises by one on each edge.
- R6: A rising edge on either button during hold restarts the hold count at 0. The block stays in hold.
- R7: When the hold count is HOLD_LEN-1, no press arrives and both buttons are low, the next edge gives idle, count 0 and `sel` 0.
- R8: When the hold count is HOLD_LEN-1 and either button is still high, the hold window restarts at count 0.
- R9: A press is a 0-to-1 change against the previous cycle's level. A button held high is not a press, either in arm or hold, or for leaving idle.
- R10: In idle, a rising edge on `btn_b` alone, a rising edge on both buttons together, or a rising edge on `btn_a` while `btn_b` is high does not start arming.
- R11: A synchronous active-high `rst` forces idle, count 0 and `sel` 0.
- R12: `dbg_state` encodes idle as 0, arm as 1 and hold as 2. Everything updates on the rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| btn_a | input | 1 | First button level; the only one that can start arming |
| btn_b | input | 1 | Second button level |
| sel | output | 1 | Selector, high throughout the hold window |
| dbg_count | output | CW | Current window count, $clog2(max(ARM_LEN,HOLD_LEN)) bits |
| dbg_state | output | 2 | Current state: 0 idle, 1 arm, 2 hold |

## Verification
The bench builds the block with the default windows, ARM_LEN of 5 and HOLD_LEN of 12. These are short enough to sweep every position. A second press is placed at each arming count and a restart at each hold count, and every following window is run out to its last count and the return to idle. The small sizes also bring the hold-expiry edge with a button still high within reach of a few dozen cycles, together with the ignored-press cases in idle.

// File: rtl/btn_window_timer.sv
module btn_window_timer #(
  parameter int ARM_LEN  = 5,
  parameter int HOLD_LEN = 12,
  localparam int MAXLEN  = (ARM_LEN > HOLD_LEN) ? ARM_LEN : HOLD_LEN,
  localparam int CW      = (MAXLEN > 1) ? $clog2(MAXLEN) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          btn_a,
  input  logic          btn_b,
  output logic          sel,
  output logic [CW-1:0] dbg_count,
  output logic [1:0]    dbg_state
);

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_ARM = 2'd1, ST_HOLD = 2'd2} st_t;

  st_t           st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          a_q, b_q;
  logic          rise_a, rise_b, press, arm_go, arm_last, hold_last;

  always_ff @(posedge clk) begin
    a_q <= btn_a;
    b_q <= btn_b;
  end

  assign rise_a    = btn_a & ~a_q;
  assign rise_b    = btn_b & ~b_q;
  assign press     = rise_a | rise_b;
  assign arm_go    = rise_a & ~btn_b;
  assign arm_last  = (cnt == CW'(ARM_LEN - 1));
  assign hold_last = (cnt == CW'(HOLD_LEN - 1));

  always_comb begin
    st_n  = st;
    cnt_n = cnt + CW'(1);
    case (st)
      ST_IDLE: begin
        cnt_n = '0;
        if (arm_go) st_n = ST_ARM;
      end
      ST_ARM: begin
        if (press) begin
          st_n  = ST_HOLD;
          cnt_n = '0;
        end else if (arm_last) begin
          st_n  = ST_IDLE;
          cnt_n = '0;
        end
      end
      ST_HOLD: begin
        if (press || (hold_last && (btn_a || btn_b))) begin
          cnt_n = '0;
        end else if (hold_last) begin
          st_n  = ST_IDLE;
          cnt_n = '0;
        end
      end
      default: begin
        st_n  = ST_IDLE;
        cnt_n = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
    end
  end

  assign sel       = (st == ST_HOLD);
  assign dbg_count = cnt;
  assign dbg_state = st;

  p_reset_r11: assert property (@(posedge clk)
    rst |=> (dbg_state == 2'd0 && dbg_count == '0 && !sel));

  p_idle_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> (cnt == '0 && !sel));

  p_arm_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ARM) |-> (cnt < CW'(ARM_LEN)));

  p_arm_timeout_r3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ARM && arm_last && !press) |=> (st == ST_IDLE && !sel));

  p_arm_to_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ARM && press) |=> (sel && cnt == '0));

  p_hold_sel_r5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HOLD && !hold_last) |=> sel);

  p_hold_restart_r6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HOLD && press) |=> (sel && cnt == '0));

  p_hold_held_r8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HOLD && hold_last && (btn_a || btn_b)) |=> (sel && cnt == '0));

  p_idle_ignore_r10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && !(btn_a && !a_q && !btn_b)) |=> (st == ST_IDLE));

endmodule

// File: tb/sim_btn_window_timer.sv
`timescale 1ns/1ps
module sim_btn_window_timer;
  localparam int ARM_LEN  = 5;
  localparam int HOLD_LEN = 12;
  localparam int CW       = $clog2(HOLD_LEN);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          btn_a = 1'b0;
  logic          btn_b = 1'b0;
  logic          sel;
  logic [CW-1:0] dbg_count;
  logic [1:0]    dbg_state;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  btn_window_timer #(.ARM_LEN(ARM_LEN), .HOLD_LEN(HOLD_LEN)) u0 (
    .clk(clk), .rst(rst), .btn_a(btn_a), .btn_b(btn_b),
    .sel(sel), .dbg_count(dbg_count), .dbg_state(dbg_state)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag, input int st, input int cn, input int sl);
    chk({tag, " state"}, int'(dbg_state), st);
    chk({tag, " count"}, int'(dbg_count), cn);
    chk({tag, " sel"}, int'(sel), sl);
  endtask

  task automatic enter_hold(input bit keep_b);
    btn_a = 1'b1; step();
    btn_a = 1'b0; btn_b = 1'b1; step();
    chk_all("R4 hold entry", 2, 0, 1);
    if (!keep_b) btn_b = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements): actual hung expected finished");
    finish_run();
  end

  initial begin
    @(negedge clk); step(); step();
    rst = 1'b0;
    chk_all("R11 reset state", 0, 0, 0);
    repeat (3) step();
    chk_all("R1 idle quiet", 0, 0, 0);

    // R2, R3, R9: arm with btn_a held throughout; the held level is no press
    btn_a = 1'b1;
    for (int j = 0; j < ARM_LEN; j++) begin
      step();
      chk_all("R2 R12 arm count", 1, j, 0);
    end
    step();
    chk_all("R3 arm timeout", 0, 0, 0);
    step();
    chk_all("R9 held btn_a stays idle", 0, 0, 0);
    btn_a = 1'b0; step();

    // R4, R5, R7: second press at every arming count
    for (int off = 0; off < ARM_LEN; off++) begin
      btn_a = 1'b1; step();
      chk_all("R2 arm start", 1, 0, 0);
      btn_a = 1'b0;
      repeat (off) step();
      chk("R2 arm offset count", int'(dbg_count), off);
      btn_b = 1'b1; step();
      chk_all("R4 press in arm", 2, 0, 1);
      btn_b = 1'b0;
      for (int j = 1; j < HOLD_LEN; j++) begin
        step();
        chk_all("R5 hold count", 2, j, 1);
      end
      step();
      chk_all("R7 hold expiry", 0, 0, 0);
    end

    // R6: restart at every hold count
    for (int r = 0; r < HOLD_LEN; r++) begin
      enter_hold(1'b0);
      repeat (r) step();
      chk("R6 pre-restart count", int'(dbg_count), r);
      btn_a = 1'b1; step();
      chk_all("R6 restart", 2, 0, 1);
      btn_a = 1'b0;
      repeat (HOLD_LEN - 1) step();
      chk_all("R5 last hold cycle", 2, HOLD_LEN - 1, 1);
      step();
      chk_all("R7 expiry after restart", 0, 0, 0);
    end

    // R8, R9: btn_b held through the whole hold window
    enter_hold(1'b1);
    for (int j = 1; j < HOLD_LEN; j++) begin
      step();
      chk_all("R9 held btn_b no restart", 2, j, 1);
    end
    step();
    chk_all("R8 held at expiry restarts", 2, 0, 1);
    btn_b = 1'b0;
    repeat (HOLD_LEN - 1) step();
    step();
    chk_all("R7 expiry after held restart", 0, 0, 0);

    // R10: ignored presses in idle
    btn_b = 1'b1; step();
    chk_all("R10 btn_b alone", 0, 0, 0);
    btn_a = 1'b1; step();
    chk_all("R10 btn_a while btn_b high", 0, 0, 0);
    btn_a = 1'b0; btn_b = 1'b0; step();
    btn_a = 1'b1; btn_b = 1'b1; step();
    chk_all("R10 both together", 0, 0, 0);
    btn_a = 1'b0; btn_b = 1'b0; step();
    chk_all("R1 idle after release", 0, 0, 0);

    // R11: reset in the middle of hold
    enter_hold(1'b0);
    step();
    rst = 1'b1; step();
    chk_all("R11 reset from hold", 0, 0, 0);
    rst = 1'b0; step();
    chk_all("R11 idle after reset", 0, 0, 0);

    finish_run();
  end
endmodule